// File: doc/BRIEF.md
# Keyboard/Mouse Controller Command Engine

This block is the host-facing command engine of a PC-style keyboard and mouse controller. The host writes bytes through a single write port, and one select bit decides whether a byte is a controller command or a data byte. The engine holds the mode byte, the status byte, the output-port byte and a latch for a command that still waits for its parameter. It decodes commands and emits reply bytes through a push interface toward a keyboard reply queue or an auxiliary reply queue. It also forwards plain data bytes to the keyboard device or, when asked, to the auxiliary device.

The output-port byte drives the A20 gate directly, and the engine raises a one-cycle system reset request whenever a command or an output-port write asks for a CPU reset. The two reply queues report through two flags whether they hold data. From those flags and the mode byte the engine forms the output-buffer status bits and the two interrupt lines. Every effect of a host write appears on the outputs one clock after the write cycle.

Top module: `kbc_cmd_unit`

## Requirements
- R1: After reset, statusOut reads 0x18 while no queue holds data, a20Gate is 1 and xlateEn is 0. A mode read returns 0x03 and an output-port read returns 0x03.
- R2: Command 0x20 pushes the current mode byte into the keyboard queue. This shows as replyValid=1, replyAux=0 and replyData equal to the mode byte.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only latch themselves. The next data write is taken as their parameter and then clears the latch. A data write after 0x60 loads the mode byte, and xlateEn follows mode bit 6.
- R4: A data write made while no command is latched is forwarded to the keyboard: devFwdValid=1, devFwdAux=0 and devFwdData equal to the byte.
- R5: The parameter of 0xD2 is pushed into the keyboard queue (replyAux=0), and the parameter of 0xD3 into the auxiliary queue (replyAux=1). The parameter of 0xD4 is forwarded to the auxiliary device (devFwdAux=1), and no reply is pushed.
- R6: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9, 0xAB and 0xC0 each push 0x00, and command 0xD0 pushes the output-port byte.
- R7: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, and the keyboard interrupt follows that change at once.
- R8: Any command whose upper nibble is 0xF gives a one-cycle sysResetReq when its bit 0 is 0, and has no effect when its bit 0 is 1.
- R9: Command 0xDF sets output-port bit 1, which drives a20Gate high. Command 0xDD clears that bit and drives a20Gate low.
- R10: The parameter of 0xD1 replaces the output-port byte, and a20Gate follows its bit 1. A one-cycle sysResetReq is issued when its bit 0 is 0.
- R11: Status bit 3 is 1 after a command write and 0 after a data write.
- R12: Status bit 0 is 1 when either queue holds data. Status bit 5 is 1 only when the auxiliary queue alone holds data. irqAux = auxiliary-only data AND mode bit 1. irqKbd = keyboard data present AND mode bit 0 AND NOT mode bit 4.
- R13: Any other command byte gives a one-cycle badCmd pulse and changes no register, pushes no reply and forwards nothing.
- R14: replyValid, devFwdValid, sysResetReq and badCmd are high only in the cycle that follows the write that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe, one cycle per byte |
| hostSelCmd | input | 1 | 1 selects the command port, 0 selects the data port |
| hostWrData | input | 8 | Byte written by the host |
| kbdHasData | input | 1 | Keyboard reply queue is not empty |
| auxHasData | input | 1 | Auxiliary reply queue is not empty |
| statusOut | output | 8 | Status byte for host reads |
| replyValid | output | 1 | Push strobe toward a reply queue |
| replyAux | output | 1 | Push target: 1 auxiliary, 0 keyboard |
| replyData | output | 8 | Byte pushed |
| devFwdValid | output | 1 | Byte forwarded to a device |
| devFwdAux | output | 1 | Forward target: 1 auxiliary device, 0 keyboard |
| devFwdData | output | 8 | Forwarded byte |
| a20Gate | output | 1 | A20 gate, output-port bit 1 |
| sysResetReq | output | 1 | One-cycle CPU reset request |
| xlateEn | output | 1 | Scan-code translation enable, mode bit 6 |
| badCmd | output | 1 | One-cycle pulse for an unsupported command |
| irqKbd | output | 1 | Keyboard interrupt |
| irqAux | output | 1 | Auxiliary interrupt |

## Verification
The assertions take for granted that hostWrEn is low during reset, that each host write lasts exactly one cycle, and that the two queue flags change only between clock edges. The bench keeps within these limits. It drives every input on the falling edge, drops hostWrEn on the falling edge after each write, and holds hostWrEn low through reset. It samples registered outputs on the falling edge that follows the write edge. It samples the interrupt and status results of queue-flag changes shortly after the flags move.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // controller opcodes
  localparam byte_t OP_RD_MODE   = 8'h20;
  localparam byte_t OP_WR_MODE   = 8'h60;
  localparam byte_t OP_AUX_OFF   = 8'hA7;
  localparam byte_t OP_AUX_ON    = 8'hA8;
  localparam byte_t OP_AUX_TEST  = 8'hA9;
  localparam byte_t OP_SELF_TEST = 8'hAA;
  localparam byte_t OP_KBD_TEST  = 8'hAB;
  localparam byte_t OP_KBD_OFF   = 8'hAD;
  localparam byte_t OP_KBD_ON    = 8'hAE;
  localparam byte_t OP_RD_INPUT  = 8'hC0;
  localparam byte_t OP_RD_PORT   = 8'hD0;
  localparam byte_t OP_WR_PORT   = 8'hD1;
  localparam byte_t OP_WR_KOBUF  = 8'hD2;
  localparam byte_t OP_WR_AOBUF  = 8'hD3;
  localparam byte_t OP_WR_AUXDEV = 8'hD4;
  localparam byte_t OP_GATE_OFF  = 8'hDD;
  localparam byte_t OP_GATE_ON   = 8'hDF;
  localparam byte_t NO_PENDING   = 8'h00;
  localparam byte_t SELF_OK_BYTE = 8'h55;

  // field positions
  localparam int MODE_KIRQ  = 0;
  localparam int MODE_AIRQ  = 1;
  localparam int MODE_KOFF  = 4;
  localparam int MODE_AOFF  = 5;
  localparam int MODE_XLATE = 6;
  localparam int PORT_NRST  = 0;
  localparam int PORT_GATE  = 1;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_MODE, SRC_PORT, SRC_SELF, SRC_HOST
  } reply_src_e;

  typedef struct packed {
    logic       cmdWr;
    logic       dataWr;
    logic       push;
    logic       pushAux;
    reply_src_e src;
    logic       modeLoad;
    logic       portLoad;
    logic       aoffSet;
    logic       aoffClr;
    logic       koffSet;
    logic       koffClr;
    logic       selfSet;
    logic       gateSet;
    logic       gateClr;
    logic       rstReq;
    logic       fwd;
    logic       fwdAux;
    logic       badOp;
  } kbc_stb_t;
endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrEn,
  input  logic     wrCmd,
  input  byte_t    wrData,
  output kbc_stb_t stb
);
  byte_t pendCmd, pendNext;

  always_comb begin
    stb      = '0;
    stb.src  = SRC_ZERO;
    pendNext = pendCmd;
    if (wrEn && wrCmd) begin
      stb.cmdWr = 1'b1;
      if (wrData[BYTE_W-1 -: 4] == 4'hF) begin
        stb.rstReq = ~wrData[0];
      end else begin
        unique case (wrData)
          OP_RD_MODE:   begin stb.push = 1'b1; stb.src = SRC_MODE; end
          OP_WR_MODE, OP_WR_PORT, OP_WR_KOBUF, OP_WR_AOBUF, OP_WR_AUXDEV:
                        pendNext = wrData;
          OP_AUX_OFF:   stb.aoffSet = 1'b1;
          OP_AUX_ON:    stb.aoffClr = 1'b1;
          OP_KBD_OFF:   stb.koffSet = 1'b1;
          OP_KBD_ON:    stb.koffClr = 1'b1;
          OP_SELF_TEST: begin stb.selfSet = 1'b1; stb.push = 1'b1; stb.src = SRC_SELF; end
          OP_AUX_TEST, OP_KBD_TEST, OP_RD_INPUT:
                        begin stb.push = 1'b1; stb.src = SRC_ZERO; end
          OP_RD_PORT:   begin stb.push = 1'b1; stb.src = SRC_PORT; end
          OP_GATE_ON:   stb.gateSet = 1'b1;
          OP_GATE_OFF:  stb.gateClr = 1'b1;
          default:      stb.badOp = 1'b1;
        endcase
      end
    end else if (wrEn) begin
      stb.dataWr = 1'b1;
      pendNext   = NO_PENDING;
      unique case (pendCmd)
        OP_WR_MODE:   stb.modeLoad = 1'b1;
        OP_WR_PORT:   begin stb.portLoad = 1'b1; stb.rstReq = ~wrData[PORT_NRST]; end
        OP_WR_KOBUF:  begin stb.push = 1'b1; stb.src = SRC_HOST; end
        OP_WR_AOBUF:  begin stb.push = 1'b1; stb.pushAux = 1'b1; stb.src = SRC_HOST; end
        OP_WR_AUXDEV: begin stb.fwd = 1'b1; stb.fwdAux = 1'b1; end
        default:      stb.fwd = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendCmd <= NO_PENDING;
    else        pendCmd <= pendNext;
  end
endmodule

// File: rtl/kbc_dpath.sv
module kbc_dpath
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t PORT_INIT = 8'h03
) (
  input  logic     clk,
  input  logic     rst_n,
  input  kbc_stb_t stb,
  input  byte_t    wrData,
  input  logic     kbdHasData,
  input  logic     auxHasData,
  output byte_t    statusOut,
  output logic     replyValid,
  output logic     replyAux,
  output byte_t    replyData,
  output logic     devFwdValid,
  output logic     devFwdAux,
  output byte_t    devFwdData,
  output logic     a20Gate,
  output logic     sysResetReq,
  output logic     xlateEn,
  output logic     badCmd,
  output logic     irqKbd,
  output logic     irqAux
);
  byte_t modeReg, portReg, replyNext;
  logic  selfOk, lastCmd, anyData, auxOnly;

  always_comb begin
    unique case (stb.src)
      SRC_MODE: replyNext = modeReg;
      SRC_PORT: replyNext = portReg;
      SRC_SELF: replyNext = SELF_OK_BYTE;
      SRC_HOST: replyNext = wrData;
      default:  replyNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg     <= MODE_INIT;
      portReg     <= PORT_INIT;
      selfOk      <= 1'b0;
      lastCmd     <= 1'b1;
      replyValid  <= 1'b0;
      replyAux    <= 1'b0;
      replyData   <= '0;
      devFwdValid <= 1'b0;
      devFwdAux   <= 1'b0;
      devFwdData  <= '0;
      sysResetReq <= 1'b0;
      badCmd      <= 1'b0;
    end else begin
      if (stb.cmdWr)       lastCmd <= 1'b1;
      else if (stb.dataWr) lastCmd <= 1'b0;

      if (stb.modeLoad)     modeReg <= wrData;
      else if (stb.aoffSet) modeReg[MODE_AOFF] <= 1'b1;
      else if (stb.aoffClr) modeReg[MODE_AOFF] <= 1'b0;
      else if (stb.koffSet) modeReg[MODE_KOFF] <= 1'b1;
      else if (stb.koffClr) modeReg[MODE_KOFF] <= 1'b0;

      if (stb.portLoad)     portReg <= wrData;
      else if (stb.gateSet) portReg[PORT_GATE] <= 1'b1;
      else if (stb.gateClr) portReg[PORT_GATE] <= 1'b0;

      if (stb.selfSet) selfOk <= 1'b1;

      replyValid <= stb.push;
      replyAux   <= stb.pushAux;
      if (stb.push) replyData <= replyNext;

      devFwdValid <= stb.fwd;
      devFwdAux   <= stb.fwdAux;
      if (stb.fwd) devFwdData <= wrData;

      sysResetReq <= stb.rstReq;
      badCmd      <= stb.badOp;
    end
  end

  assign anyData = kbdHasData | auxHasData;
  assign auxOnly = auxHasData & ~kbdHasData;
  // bit7 parity, bit6 timeout, bit5 aux-full, bit4 unlocked, bit3 last-cmd,
  // bit2 self-test, bit1 input-full, bit0 output-full
  assign statusOut = {2'b00, auxOnly, 1'b1, lastCmd, selfOk, 1'b0, anyData};
  assign irqKbd    = kbdHasData & modeReg[MODE_KIRQ] & ~modeReg[MODE_KOFF];
  assign irqAux    = auxOnly & modeReg[MODE_AIRQ];
  assign a20Gate   = portReg[PORT_GATE];
  assign xlateEn   = modeReg[MODE_XLATE];
endmodule

// File: rtl/kbc_cmd_unit.sv
module kbc_cmd_unit
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_INIT = 8'h03,
  parameter logic [7:0] PORT_INIT = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWrEn,
  input  logic       hostSelCmd,
  input  logic [7:0] hostWrData,
  input  logic       kbdHasData,
  input  logic       auxHasData,
  output logic [7:0] statusOut,
  output logic       replyValid,
  output logic       replyAux,
  output logic [7:0] replyData,
  output logic       devFwdValid,
  output logic       devFwdAux,
  output logic [7:0] devFwdData,
  output logic       a20Gate,
  output logic       sysResetReq,
  output logic       xlateEn,
  output logic       badCmd,
  output logic       irqKbd,
  output logic       irqAux
);
  kbc_stb_t stb;

  kbc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(hostWrEn), .wrCmd(hostSelCmd),
    .wrData(hostWrData), .stb(stb)
  );

  kbc_dpath #(.MODE_INIT(MODE_INIT), .PORT_INIT(PORT_INIT)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(hostWrData),
    .kbdHasData(kbdHasData), .auxHasData(auxHasData),
    .statusOut(statusOut), .replyValid(replyValid), .replyAux(replyAux),
    .replyData(replyData), .devFwdValid(devFwdValid), .devFwdAux(devFwdAux),
    .devFwdData(devFwdData), .a20Gate(a20Gate), .sysResetReq(sysResetReq),
    .xlateEn(xlateEn), .badCmd(badCmd), .irqKbd(irqKbd), .irqAux(irqAux)
  );
endmodule

// File: rtl/kbc_cmd_chk.sv
module kbc_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hostWrEn,
  input logic       hostSelCmd,
  input logic       kbdHasData,
  input logic       auxHasData,
  input logic [7:0] statusOut,
  input logic       replyValid,
  input logic       devFwdValid,
  input logic       devFwdAux,
  input logic       a20Gate,
  input logic       sysResetReq,
  input logic       badCmd,
  input logic       irqKbd,
  input logic       irqAux
);
  p_reset_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |-> $past(hostWrEn));
  p_reply_from_write_r14: assert property (@(posedge clk) disable iff (!rst_n)
    replyValid |-> $past(hostWrEn));
  p_fwd_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    devFwdValid |-> $past(hostWrEn && !hostSelCmd));
  p_bad_from_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    badCmd |-> $past(hostWrEn && hostSelCmd));
  p_bad_no_reply_r13: assert property (@(posedge clk) disable iff (!rst_n)
    badCmd |-> !replyValid && !devFwdValid && !sysResetReq);
  p_gate_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hostWrEn) |-> $stable(a20Gate));
  p_lastcmd_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hostWrEn) |-> statusOut[3] == $past(hostSelCmd));
  p_aux_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irqAux |-> auxHasData && !kbdHasData);
  p_kbd_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irqKbd |-> kbdHasData);
  p_irq_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(irqKbd && irqAux));
endmodule

bind kbc_cmd_unit kbc_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostSelCmd(hostSelCmd),
  .kbdHasData(kbdHasData), .auxHasData(auxHasData), .statusOut(statusOut),
  .replyValid(replyValid), .devFwdValid(devFwdValid), .devFwdAux(devFwdAux),
  .a20Gate(a20Gate), .sysResetReq(sysResetReq), .badCmd(badCmd),
  .irqKbd(irqKbd), .irqAux(irqAux)
);

// File: tb/sim_kbc_cmd_unit.sv
`timescale 1ns/100ps
module sim_kbc_cmd_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hostWrEn = 1'b0, hostSelCmd = 1'b0;
  logic [7:0] hostWrData = '0;
  logic kbdHasData = 1'b0, auxHasData = 1'b0;
  logic [7:0] statusOut, replyData, devFwdData;
  logic replyValid, replyAux, devFwdValid, devFwdAux, a20Gate, sysResetReq;
  logic xlateEn, badCmd, irqKbd, irqAux;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_cmd_unit u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostSelCmd = sel; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic expectReply(input string req, input logic aux, input logic [7:0] d);
    chk({req, " push"}, {7'd0, replyValid}, 8'd1);
    chk({req, " target"}, {7'd0, replyAux}, {7'd0, aux});
    chk({req, " byte"}, replyData, d);
  endtask

  task automatic t_reset();
    chk("R1 status", statusOut, 8'h18);
    chk("R1 gate", {7'd0, a20Gate}, 8'd1);
    chk("R1 xlate", {7'd0, xlateEn}, 8'd0);
    chk("R1 irq", {6'd0, irqKbd, irqAux}, 8'd0);
    wr(1'b1, 8'h20); expectReply("R2 R1 mode read", 1'b0, 8'h03);
    idle(); chk("R14 push drops", {7'd0, replyValid}, 8'd0);
    wr(1'b1, 8'hD0); expectReply("R1 port read", 1'b0, 8'h03);
  endtask

  task automatic t_mode_write();
    wr(1'b1, 8'h60);
    chk("R3 latch no push", {7'd0, replyValid}, 8'd0);
    chk("R3 latch no fwd", {7'd0, devFwdValid}, 8'd0);
    wr(1'b0, 8'h43);
    chk("R3 param not forwarded", {7'd0, devFwdValid}, 8'd0);
    chk("R3 xlate on", {7'd0, xlateEn}, 8'd1);
    wr(1'b1, 8'h20); expectReply("R3 mode readback", 1'b0, 8'h43);
    wr(1'b0, 8'h5A);
    chk("R3 latch cleared fwd", {7'd0, devFwdValid}, 8'd1);
    chk("R3 latch cleared byte", devFwdData, 8'h5A);
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);
    chk("R3 xlate off", {7'd0, xlateEn}, 8'd0);
  endtask

  task automatic t_forward();
    wr(1'b0, 8'hED);
    chk("R4 fwd", {7'd0, devFwdValid}, 8'd1);
    chk("R4 target kbd", {7'd0, devFwdAux}, 8'd0);
    chk("R4 byte", devFwdData, 8'hED);
    chk("R11 data write", {7'd0, statusOut[3]}, 8'd0);
    chk("R4 no push", {7'd0, replyValid}, 8'd0);
    idle(); chk("R14 fwd drops", {7'd0, devFwdValid}, 8'd0);
    wr(1'b1, 8'hAE);
    chk("R11 cmd write", {7'd0, statusOut[3]}, 8'd1);
  endtask

  task automatic t_obuf();
    wr(1'b1, 8'hD2); wr(1'b0, 8'hAB); expectReply("R5 kbd obuf", 1'b0, 8'hAB);
    wr(1'b1, 8'hD3); wr(1'b0, 8'h77); expectReply("R5 aux obuf", 1'b1, 8'h77);
    wr(1'b1, 8'hD4); wr(1'b0, 8'hF4);
    chk("R5 aux fwd", {6'd0, devFwdValid, devFwdAux}, 8'd3);
    chk("R5 aux fwd byte", devFwdData, 8'hF4);
    chk("R5 aux fwd no push", {7'd0, replyValid}, 8'd0);
  endtask

  task automatic t_tests();
    chk("R6 selftest clear", {7'd0, statusOut[2]}, 8'd0);
    wr(1'b1, 8'hAA); expectReply("R6 selftest", 1'b0, 8'h55);
    chk("R6 selftest bit", {7'd0, statusOut[2]}, 8'd1);
    wr(1'b1, 8'hA9); expectReply("R6 aux test", 1'b0, 8'h00);
    wr(1'b1, 8'hAB); expectReply("R6 kbd test", 1'b0, 8'h00);
    wr(1'b1, 8'hC0); expectReply("R6 input read", 1'b0, 8'h00);
  endtask

  task automatic t_disable();
    @(negedge clk); kbdHasData = 1'b1; #1;
    chk("R7 R12 kbd irq on", {7'd0, irqKbd}, 8'd1);
    wr(1'b1, 8'hAD);
    chk("R7 kbd off irq", {7'd0, irqKbd}, 8'd0);
    wr(1'b1, 8'h20); expectReply("R7 kbd off mode", 1'b0, 8'h13);
    wr(1'b1, 8'hAE);
    chk("R7 kbd on irq", {7'd0, irqKbd}, 8'd1);
    wr(1'b1, 8'hA7);
    wr(1'b1, 8'h20); expectReply("R7 aux off mode", 1'b0, 8'h23);
    wr(1'b1, 8'hA8);
    wr(1'b1, 8'h20); expectReply("R7 aux on mode", 1'b0, 8'h03);
    @(negedge clk); kbdHasData = 1'b0;
  endtask

  task automatic t_pulse();
    wr(1'b1, 8'hFE); chk("R8 FE reset", {7'd0, sysResetReq}, 8'd1);
    idle();          chk("R14 reset drops", {7'd0, sysResetReq}, 8'd0);
    wr(1'b1, 8'hFF); chk("R8 FF nop", {7'd0, sysResetReq}, 8'd0);
    chk("R8 FF not bad", {7'd0, badCmd}, 8'd0);
    wr(1'b1, 8'hF0); chk("R8 F0 reset", {7'd0, sysResetReq}, 8'd1);
    wr(1'b1, 8'hFD); chk("R8 FD nop", {6'd0, sysResetReq, badCmd}, 8'd0);
  endtask

  task automatic t_gate();
    wr(1'b1, 8'hDD); chk("R9 gate off", {7'd0, a20Gate}, 8'd0);
    wr(1'b1, 8'hD0); expectReply("R9 port after off", 1'b0, 8'h01);
    wr(1'b1, 8'hDF); chk("R9 gate on", {7'd0, a20Gate}, 8'd1);
    wr(1'b1, 8'hD0); expectReply("R9 port after on", 1'b0, 8'h03);
  endtask

  task automatic t_port();
    wr(1'b1, 8'hD1); wr(1'b0, 8'h01);
    chk("R10 gate low", {7'd0, a20Gate}, 8'd0);
    chk("R10 no reset", {7'd0, sysResetReq}, 8'd0);
    wr(1'b1, 8'hD0); expectReply("R10 port readback", 1'b0, 8'h01);
    wr(1'b1, 8'hD1); wr(1'b0, 8'h02);
    chk("R10 gate high", {7'd0, a20Gate}, 8'd1);
    chk("R10 reset pulse", {7'd0, sysResetReq}, 8'd1);
    wr(1'b1, 8'hD0); expectReply("R10 port readback2", 1'b0, 8'h02);
    wr(1'b1, 8'hD1); wr(1'b0, 8'h03);
  endtask

  task automatic t_irq();
    @(negedge clk); auxHasData = 1'b1; #1;
    chk("R12 aux only status", {statusOut[5], statusOut[0]}, 8'd3);
    chk("R12 aux only irqs", {6'd0, irqKbd, irqAux}, 8'd1);
    @(negedge clk); kbdHasData = 1'b1; #1;
    chk("R12 both status", {statusOut[5], statusOut[0]}, 8'd1);
    chk("R12 both irqs", {6'd0, irqKbd, irqAux}, 8'd2);
    @(negedge clk); kbdHasData = 1'b0;
    wr(1'b1, 8'h60); wr(1'b0, 8'h00);
    chk("R12 aux irq masked", {6'd0, irqKbd, irqAux}, 8'd0);
    wr(1'b1, 8'h60); wr(1'b0, 8'h03);
    chk("R12 aux irq back", {7'd0, irqAux}, 8'd1);
    @(negedge clk); auxHasData = 1'b0; #1;
    chk("R12 empty status", {statusOut[5], statusOut[0]}, 8'd0);
  endtask

  task automatic t_bad();
    wr(1'b1, 8'hA1);
    chk("R13 bad pulse", {7'd0, badCmd}, 8'd1);
    chk("R13 no effect", {5'd0, replyValid, devFwdValid, sysResetReq}, 8'd0);
    idle(); chk("R14 bad drops", {7'd0, badCmd}, 8'd0);
    wr(1'b1, 8'hC5); chk("R13 bad C5", {7'd0, badCmd}, 8'd1);
    wr(1'b1, 8'h20); expectReply("R13 mode kept", 1'b0, 8'h03);
    wr(1'b1, 8'hD0); expectReply("R13 port kept", 1'b0, 8'h03);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_write();
    t_forward();
    t_obuf();
    t_tests();
    t_disable();
    t_pulse();
    t_gate();
    t_port();
    t_irq();
    t_bad();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule